// File: doc/BRIEF.md
# Two-Channel-Pair PWM with Coordinated Value Updates

This block holds several independent PWM generators behind one shared write port. Each generator has a down-counter, a period (load) value and two compare thresholds. Each threshold drives one output. The counter runs from the load value down to zero and then reloads. Its zero cycle is the boundary at which new values may be applied. Each output is high while the count is strictly above its threshold and low at or below it.

Software picks, per generator, how written load and compare values reach the counter. In immediate mode a value is used from the next cycle. In local mode it is held in a shadow copy until that generator's next zero cycle. In global mode it is held until an update request has been raised for the generator and a zero cycle follows. This lets several generators switch over on shared boundaries.

A sync input restarts chosen counters on one edge. An output-enable mask can be applied at once or at the owning generator's zero. A fault input forces selected outputs low. A debug stall can freeze the counters.

Top module: `pwm_sync_top`

## Requirements
- R1: After reset every count, value, mode, enable and request flag is zero. With load L a counter runs L, L-1, …, 0 and then reloads, so its period is L+1 cycles.
- R2: Output 2g follows generator g's first compare value and output 2g+1 its second. An output is high when count > compare, and it is further gated by its enable bit.
- R3: Write select 0 = load, 1 = first compare, 2 = second compare, 3 = control. Control data bits [1:0] hold the update mode. In mode 0 (immediate), a load or compare write is used from the next cycle.
- R4: In modes 1 and 3 (local), a load or compare write is held back and applied at the end of the generator's next zero cycle. A write made in a zero cycle waits for the following zero.
- R5: In mode 2 (global), held values are applied only at a zero cycle that occurs while the update request flag is already set. Until then the old values stay in use.
- R6: A glob_req bit sets the generator's request flag, which glob_pend shows. The flag clears at the zero cycle where a global commit happens.
- R7: A sync_req bit forces that counter to zero on the next edge. Several bits set together reset their counters on the same edge. Sync takes priority over stall.
- R8: With oen_sync low, an enable-mask write takes effect on the next cycle. With oen_sync high, the new mask is held, and each generator's two bits switch at that generator's zero cycle.
- R9: While fault is high, each output whose fault_en bit is set reads low in the same cycle.
- R10: While dbg_stall and stall_en are both high, counters hold their value and no zero-cycle commit happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_gen | input | GW | Target generator index |
| wr_sel | input | 2 | Target register: load, compare A, compare B, control |
| wr_data | input | CW | Write data |
| sync_req | input | NGEN | Counter restart, one bit per generator |
| glob_req | input | NGEN | Global update request, one bit per generator |
| oen_wr | input | 1 | Enable-mask write strobe |
| oen_data | input | 2*NGEN | Enable-mask write data |
| oen_sync | input | 1 | Enable mask commits at zero when high |
| fault_en | input | 2*NGEN | Per-output fault gating |
| fault | input | 1 | Fault condition, active high |
| stall_en | input | 1 | Allows debug stall to freeze counters |
| dbg_stall | input | 1 | Debug stall request |
| pwm_out | output | 2*NGEN | PWM outputs |
| glob_pend | output | NGEN | Global request flags still waiting |
| cnt_out | output | NGEN*CW | Current counts, generator g in bits [g*CW +: CW] |

## Verification
The first directed stretch uses fixed periods in immediate mode and shows that counting and compare thresholds are correct on their own. Later stretches write the same values in local and global mode, so an early or late commit shows up as a shifted period. A global write is left pending for many cycles before the request is raised, which separates "held" from "lost". Simultaneous sync bits, sync during a stall and faults with mixed gating masks each isolate one override path. A long seeded random run mixes writes in zero cycles, mode changes while values are pending and requests raised in commit cycles, all checked against a cycle-level reference model.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    typedef enum logic [1:0] {
        UPD_IMM    = 2'd0,
        UPD_LOCAL  = 2'd1,
        UPD_GLOBAL = 2'd2,
        UPD_LOCAL2 = 2'd3
    } upd_mode_e;

    typedef enum logic [1:0] {
        SEL_LOAD = 2'd0,
        SEL_CMPA = 2'd1,
        SEL_CMPB = 2'd2,
        SEL_CTRL = 2'd3
    } wsel_e;

endpackage

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_sync_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_sel_i,
    input  logic [CW-1:0] wr_data_i,
    input  logic          sync_i,
    input  logic          greq_i,
    input  logic          frozen_i,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o,
    output logic [1:0]    raw_o,
    output logic          pend_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] ld_a;
        logic [CW-1:0] ca_a;
        logic [CW-1:0] cb_a;
        logic [CW-1:0] ld_s;
        logic [CW-1:0] ca_s;
        logic [CW-1:0] cb_s;
        upd_mode_e     mode;
        logic          flag;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    zero, c_glob, c_loc, commit;

    always_comb begin
        st_d   = st_q;
        zero   = (st_q.cnt == '0) && !frozen_i;
        c_glob = zero && (st_q.mode == UPD_GLOBAL) && st_q.flag;
        c_loc  = zero && ((st_q.mode == UPD_LOCAL) || (st_q.mode == UPD_LOCAL2));
        commit = c_glob || c_loc;

        if (sync_i)
            st_d.cnt = '0;
        else if (frozen_i)
            st_d.cnt = st_q.cnt;
        else if (st_q.cnt == '0)
            st_d.cnt = commit ? st_q.ld_s : st_q.ld_a;
        else
            st_d.cnt = st_q.cnt - 1'b1;

        if (commit) begin
            st_d.ld_a = st_q.ld_s;
            st_d.ca_a = st_q.ca_s;
            st_d.cb_a = st_q.cb_s;
        end

        if (wr_en_i) begin
            case (wsel_e'(wr_sel_i))
                SEL_LOAD: begin
                    st_d.ld_s = wr_data_i;
                    if (st_q.mode == UPD_IMM) st_d.ld_a = wr_data_i;
                end
                SEL_CMPA: begin
                    st_d.ca_s = wr_data_i;
                    if (st_q.mode == UPD_IMM) st_d.ca_a = wr_data_i;
                end
                SEL_CMPB: begin
                    st_d.cb_s = wr_data_i;
                    if (st_q.mode == UPD_IMM) st_d.cb_a = wr_data_i;
                end
                default: st_d.mode = upd_mode_e'(wr_data_i[1:0]);
            endcase
        end

        st_d.flag = (st_q.flag && !c_glob) || greq_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign zero_o   = zero;
    assign raw_o[0] = st_q.cnt > st_q.ca_a;
    assign raw_o[1] = st_q.cnt > st_q.cb_a;
    assign pend_o   = st_q.flag;

    assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !frozen_i && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    assert_local_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == UPD_LOCAL && !zero) |=> ($stable(st_q.ld_a) && $stable(st_q.ca_a) && $stable(st_q.cb_a)));

    assert_global_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == UPD_GLOBAL && !st_q.flag) |=> ($stable(st_q.ld_a) && $stable(st_q.ca_a) && $stable(st_q.cb_a)));

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && zero && st_q.mode == UPD_GLOBAL && !greq_i) |=> !pend_o);

    assert_sync_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (cnt_o == '0));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_i && !sync_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pwm_outs.sv
module pwm_outs #(
    parameter int NGEN = 2,
    localparam int NOUT = 2 * NGEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            oen_wr_i,
    input  logic [NOUT-1:0] oen_data_i,
    input  logic            oen_sync_i,
    input  logic [NGEN-1:0] zero_i,
    input  logic [NOUT-1:0] raw_i,
    input  logic            fault_i,
    input  logic [NOUT-1:0] fault_en_i,
    output logic [NOUT-1:0] pwm_o
);

    typedef struct packed {
        logic [NOUT-1:0] oen_a;
        logic [NOUT-1:0] oen_s;
    } oen_st_t;

    oen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (oen_sync_i) begin
            for (int g = 0; g < NGEN; g++)
                if (zero_i[g]) st_d.oen_a[2*g +: 2] = st_q.oen_s[2*g +: 2];
        end
        if (oen_wr_i) begin
            st_d.oen_s = oen_data_i;
            if (!oen_sync_i) st_d.oen_a = oen_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = raw_i & st_q.oen_a & ~({NOUT{fault_i}} & fault_en_i);

    assert_oen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_sync_i && zero_i == '0) |=> $stable(st_q.oen_a));

    assert_fault_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |-> ((pwm_o & fault_en_i) == '0));

    assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_o & ~st_q.oen_a) == '0));

endmodule

// File: rtl/pwm_sync_top.sv
module pwm_sync_top #(
    parameter int NGEN = 2,
    parameter int CW   = 16,
    localparam int GW   = (NGEN > 1) ? $clog2(NGEN) : 1,
    localparam int NOUT = 2 * NGEN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [GW-1:0]      wr_gen,
    input  logic [1:0]         wr_sel,
    input  logic [CW-1:0]      wr_data,
    input  logic [NGEN-1:0]    sync_req,
    input  logic [NGEN-1:0]    glob_req,
    input  logic               oen_wr,
    input  logic [NOUT-1:0]    oen_data,
    input  logic               oen_sync,
    input  logic [NOUT-1:0]    fault_en,
    input  logic               fault,
    input  logic               stall_en,
    input  logic               dbg_stall,
    output logic [NOUT-1:0]    pwm_out,
    output logic [NGEN-1:0]    glob_pend,
    output logic [NGEN*CW-1:0] cnt_out
);

    logic            frozen;
    logic [NGEN-1:0] zero;
    logic [NOUT-1:0] raw;

    assign frozen = dbg_stall && stall_en;

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        pwm_gen #(.CW(CW)) u_gen (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en && (wr_gen == GW'(g))),
            .wr_sel_i  (wr_sel),
            .wr_data_i (wr_data),
            .sync_i    (sync_req[g]),
            .greq_i    (glob_req[g]),
            .frozen_i  (frozen),
            .cnt_o     (cnt_out[g*CW +: CW]),
            .zero_o    (zero[g]),
            .raw_o     (raw[2*g +: 2]),
            .pend_o    (glob_pend[g])
        );
    end

    pwm_outs #(.NGEN(NGEN)) u_outs (
        .clk        (clk),
        .rst_n      (rst_n),
        .oen_wr_i   (oen_wr),
        .oen_data_i (oen_data),
        .oen_sync_i (oen_sync),
        .zero_i     (zero),
        .raw_i      (raw),
        .fault_i    (fault),
        .fault_en_i (fault_en),
        .pwm_o      (pwm_out)
    );

endmodule

// File: tb/sim_pwm_sync_top.sv
`timescale 1ns/1ps
module sim_pwm_sync_top;
    localparam int NG = 2;
    localparam int CW = 16;
    localparam int NO = 2 * NG;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, wr_en, oen_wr, oen_sync, fault, stall_en, dbg_stall;
    logic [0:0]     wr_gen;
    logic [1:0]     wr_sel;
    logic [CW-1:0]  wr_data;
    logic [NG-1:0]  sync_req, glob_req, glob_pend;
    logic [NO-1:0]  oen_data, fault_en, pwm_out;
    logic [NG*CW-1:0] cnt_out;

    pwm_sync_top #(.NGEN(NG), .CW(CW)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    string tag = "R1";

    // reference model, from the requirements
    logic [CW-1:0] m_cnt[NG], m_lda[NG], m_caa[NG], m_cba[NG], m_lds[NG], m_cas[NG], m_cbs[NG];
    logic [1:0]    m_mode[NG];
    logic          m_flag[NG];
    logic [NO-1:0] m_oa, m_os;

    task automatic model_step();
        logic z[NG];
        logic cg, cm, frz;
        frz = dbg_stall && stall_en;
        for (int g = 0; g < NG; g++) z[g] = (m_cnt[g] == 0) && !frz;
        if (oen_sync) begin
            for (int g = 0; g < NG; g++) if (z[g]) m_oa[2*g +: 2] = m_os[2*g +: 2];
        end
        if (oen_wr) begin
            m_os = oen_data;
            if (!oen_sync) m_oa = oen_data;
        end
        for (int g = 0; g < NG; g++) begin
            cg = z[g] && m_mode[g] == 2'd2 && m_flag[g];
            cm = cg || (z[g] && (m_mode[g] == 2'd1 || m_mode[g] == 2'd3));
            if (sync_req[g]) m_cnt[g] = 0;
            else if (!frz) m_cnt[g] = (m_cnt[g] == 0) ? (cm ? m_lds[g] : m_lda[g]) : m_cnt[g] - 1;
            if (cm) begin m_lda[g] = m_lds[g]; m_caa[g] = m_cas[g]; m_cba[g] = m_cbs[g]; end
            if (wr_en && wr_gen == g[0:0]) begin
                case (wr_sel)
                    2'd0: begin m_lds[g] = wr_data; if (m_mode[g] == 0) m_lda[g] = wr_data; end
                    2'd1: begin m_cas[g] = wr_data; if (m_mode[g] == 0) m_caa[g] = wr_data; end
                    2'd2: begin m_cbs[g] = wr_data; if (m_mode[g] == 0) m_cba[g] = wr_data; end
                    default: m_mode[g] = wr_data[1:0];
                endcase
            end
            m_flag[g] = (m_flag[g] && !cg) || glob_req[g];
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_cnt[g] = 0; m_lda[g] = 0; m_caa[g] = 0; m_cba[g] = 0;
                m_lds[g] = 0; m_cas[g] = 0; m_cbs[g] = 0; m_mode[g] = 0; m_flag[g] = 0;
            end
            m_oa = 0; m_os = 0;
        end else model_step();
    end

    function automatic logic [NO-1:0] exp_out();
        logic [NO-1:0] r;
        for (int i = 0; i < NO; i++) begin
            logic [CW-1:0] c;
            c = (i % 2) ? m_cba[i/2] : m_caa[i/2];
            r[i] = (m_cnt[i/2] > c) && m_oa[i] && !(fault && fault_en[i]);
        end
        return r;
    endfunction

    task automatic cmp(string what, logic [CW-1:0] got, logic [CW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        for (int g = 0; g < NG; g++) begin
            cmp($sformatf("count g%0d", g), cnt_out[g*CW +: CW], m_cnt[g]);
            cmp($sformatf("pending g%0d", g), CW'(glob_pend[g]), CW'(m_flag[g]));
        end
        cmp("outputs", CW'(pwm_out), CW'(exp_out()));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(int g, int sel, int data);
        wr_en = 1; wr_gen = 1'(g); wr_sel = 2'(sel); wr_data = CW'(data);
        tick();
        wr_en = 0;
    endtask

    logic done = 0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; wr_en = 0; wr_gen = 0; wr_sel = 0; wr_data = 0;
        sync_req = 0; glob_req = 0; oen_wr = 0; oen_data = 0; oen_sync = 0;
        fault = 0; fault_en = 0; stall_en = 0; dbg_stall = 0;
        tag = "R1";
        run(3);                        // reset state
        rst_n = 1;
        tag = "R3";
        wr(0, 0, 5); wr(1, 0, 7); wr(0, 1, 2); wr(0, 2, 4); wr(1, 1, 3); wr(1, 2, 1);
        tag = "R8";
        oen_wr = 1; oen_data = 4'hF; tick(); oen_wr = 0;
        tag = "R2";
        run(20);
        tag = "R7";
        sync_req = 2'b11; tick(); sync_req = 0; run(10);
        tag = "R4";
        wr(0, 3, 1); wr(0, 0, 3); wr(0, 1, 1); run(15);
        tag = "R5";
        wr(0, 3, 2); wr(1, 3, 2); wr(0, 0, 9); wr(1, 0, 4); wr(1, 2, 3);
        run(20);
        tag = "R6";
        glob_req = 2'b11; tick(); glob_req = 0; run(25);
        tag = "R8";
        oen_sync = 1; oen_wr = 1; oen_data = 4'b0101; tick(); oen_wr = 0; run(15);
        tag = "R9";
        fault_en = 4'b0011; fault = 1; run(5); fault = 0; run(2);
        tag = "R10";
        stall_en = 1; dbg_stall = 1; run(6);
        sync_req = 2'b01; tick(); sync_req = 0; run(3);
        dbg_stall = 0; run(5);
        tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            wr_en = (r < 30);
            wr_gen = 1'($urandom % 2);
            wr_sel = 2'($urandom % 4);
            wr_data = (wr_sel == 3) ? CW'($urandom % 4) :
                      (wr_sel == 0) ? CW'($urandom % 13) : CW'($urandom % 14);
            sync_req = (($urandom % 100) < 5) ? 2'($urandom) : 2'b00;
            glob_req = (($urandom % 100) < 10) ? 2'($urandom) : 2'b00;
            oen_wr = (($urandom % 100) < 5);
            oen_data = 4'($urandom);
            if (($urandom % 100) < 2) oen_sync = ~oen_sync;
            if (($urandom % 100) < 10) fault = ~fault;
            if (($urandom % 100) < 3) fault_en = 4'($urandom);
            stall_en = 1;
            dbg_stall = (($urandom % 100) < 5);
            tick();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule